// File: doc/BRIEF.md
# Boosted Weak-Vote Accumulator

This block turns a vector of binary weak-classifier votes into one binary class decision. Each vote is weighted by a signed coefficient fixed at elaboration. A vote of 1 adds its coefficient to a running score, and a vote of 0 subtracts it. The class is the sign of the final score. No multiplier or per-vote selector is built. The votes are split into groups of four, and each group's four bits address a 16-entry table of precomputed signed partial sums. A pipelined binary adder tree then totals the group results.

A new vote vector can be offered on every clock together with `in_valid`. The result leaves the block a fixed number of cycles later, flagged by `out_valid`. Upstream logic, for example parallel feature comparators, drives the votes. Downstream logic uses `out_class` and, when it needs the decision margin, `out_score`.

The block has no state machine. Its only sequencing is the valid flag, which moves one stage per clock through three phases: table lookup, tree reduction and sign register.

Top module: `wv_boost_vote`

## Requirements
- R1: While `rst` is high and at the first edge after it, `out_valid`, `out_class` and `out_score` are all 0.
- R2: Vote `in_votes[i]` = 1 adds coefficient `COEFS[i*COEF_W +: COEF_W]` (two's complement) to the score, and 0 subtracts it. `out_score` equals the exact signed total.
- R3: `out_class` is 1 when the score is zero or positive, and 0 when it is negative. A score of exactly zero gives 1.
- R4: A vector accepted at clock edge k produces `out_valid` = 1 with its result after edge k+LAT, where LAT = 2 + ceil(log2(ceil(N_VOTES/4))). This gives 4 with the defaults. Vectors on consecutive clocks produce results on consecutive clocks, in order.
- R5: The score never overflows. With all votes 1 it equals +sum of the coefficients, and with all votes 0 it equals −sum. This also holds when N_VOTES is not a multiple of four, because the unused lanes of the last group contribute zero.
- R6: When `in_valid` is low, `in_votes` is ignored. While `out_valid` is low, `out_score` and `out_class` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Vote vector present this cycle |
| in_votes | input | N_VOTES | One weak-classifier vote per bit, 1 means +1 |
| out_valid | output | 1 | Result present this cycle |
| out_class | output | 1 | Decision, 1 for +1 and 0 for −1 |
| out_score | output | SUM_W | Signed weighted total (COEF_W + 2 + ceil(log2(groups)) bits) |

## Verification
The hardest case to reach from the ports is a score of exactly zero, the single point that decides between the two classes. Random vectors almost never land on it. The coefficients in the bench are therefore chosen so that one hand-picked vote pattern balances to zero. The partly filled last group is reached with the extreme all-ones and all-zeros patterns. The pipeline's ordering is reached by streaming the vector table back to back, with no idle cycles between entries.

// File: rtl/wv_pkg.sv
package wv_pkg;
    // number of four-vote groups for a given vote count
    function automatic int grp_count(input int votes);
        return (votes + 3) / 4;
    endfunction

    // pipelined adder tree depth for a given group count
    function automatic int tree_depth(input int groups);
        return (groups > 1) ? $clog2(groups) : 0;
    endfunction
endpackage

// File: rtl/wv_group_lut.sv
module wv_group_lut #(
    parameter int COEF_W = 8,
    parameter int SUM_W  = 12,
    parameter logic [4*COEF_W-1:0] GCOEFS = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [3:0]               votes,
    output logic                     out_valid,
    output logic signed [SUM_W-1:0]  psum
);
    localparam int SLOTS = 16;

    function automatic logic signed [SUM_W-1:0] coef_ext(input int k);
        logic [COEF_W-1:0] c;
        c = GCOEFS[k*COEF_W +: COEF_W];
        return {{(SUM_W-COEF_W){c[COEF_W-1]}}, c};
    endfunction

    function automatic logic signed [SUM_W-1:0] slot_value(input int addr);
        logic signed [SUM_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < 4; k++) begin
            if (((addr >> k) & 1) == 1) acc = acc + coef_ext(k);
            else                        acc = acc - coef_ext(k);
        end
        return acc;
    endfunction

    function automatic logic signed [SUM_W-1:0] abs_total();
        logic signed [SUM_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < 4; k++) begin
            if (coef_ext(k) < 0) acc = acc - coef_ext(k);
            else                 acc = acc + coef_ext(k);
        end
        return acc;
    endfunction

    localparam logic signed [SUM_W-1:0] GROUP_ABS = abs_total();

    logic signed [SUM_W-1:0] table_w [SLOTS];

    for (genvar e = 0; e < SLOTS; e++) begin : g_slot
        localparam logic signed [SUM_W-1:0] SLOT_VAL = slot_value(e);
        assign table_w[e] = SLOT_VAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            psum      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) psum <= table_w[votes];
        end
    end

    // R5: a group's partial sum never exceeds the magnitude of its coefficients
    p_group_bound_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (psum <= GROUP_ABS && psum >= -GROUP_ABS));
endmodule

// File: rtl/wv_adder_tree.sv
module wv_adder_tree #(
    parameter int N_IN  = 3,
    parameter int SUM_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [N_IN*SUM_W-1:0]    in_vals,
    output logic                     out_valid,
    output logic signed [SUM_W-1:0]  out_sum
);
    localparam int DEPTH = wv_pkg::tree_depth(N_IN);

    if (DEPTH == 0) begin : g_pass
        assign out_valid = in_valid;
        assign out_sum   = in_vals[SUM_W-1:0];
    end else begin : g_tree
        localparam int LEAVES = 1 << DEPTH;
        localparam int INNER  = LEAVES - 1;

        logic signed [SUM_W-1:0] node_v [INNER + LEAVES];
        logic signed [SUM_W-1:0] node_q [INNER];
        logic                    stage_vld [DEPTH + 1];

        assign stage_vld[0] = in_valid;

        for (genvar s = 0; s < DEPTH; s++) begin : g_vld
            always_ff @(posedge clk) begin
                if (rst) stage_vld[s+1] <= 1'b0;
                else     stage_vld[s+1] <= stage_vld[s];
            end
        end

        for (genvar lf = 0; lf < LEAVES; lf++) begin : g_leaf
            if (lf < N_IN) begin : g_used
                assign node_v[INNER + lf] = in_vals[lf*SUM_W +: SUM_W];
            end else begin : g_zero
                assign node_v[INNER + lf] = '0;
            end
        end

        for (genvar n = 0; n < INNER; n++) begin : g_node
            localparam int NODE_DEPTH = $clog2(n + 2) - 1;
            localparam int STAGE      = DEPTH - 1 - NODE_DEPTH;
            always_ff @(posedge clk) begin
                if (rst)                   node_q[n] <= '0;
                else if (stage_vld[STAGE]) node_q[n] <= node_v[2*n+1] + node_v[2*n+2];
            end
            assign node_v[n] = node_q[n];
        end

        assign out_valid = stage_vld[DEPTH];
        assign out_sum   = node_v[0];
    end
endmodule

// File: rtl/wv_boost_vote.sv
module wv_boost_vote #(
    parameter int N_VOTES = 10,
    parameter int COEF_W  = 8,
    parameter logic [N_VOTES*COEF_W-1:0] COEFS =
        {8'd8, 8'd12, 8'd35, 8'd25, 8'd15, 8'd5, 8'd40, 8'd30, 8'd20, 8'd10},
    localparam int N_GRP = wv_pkg::grp_count(N_VOTES),
    localparam int SUM_W = COEF_W + 2 + wv_pkg::tree_depth(N_GRP)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [N_VOTES-1:0] in_votes,
    output logic               out_valid,
    output logic               out_class,
    output logic [SUM_W-1:0]   out_score
);
    localparam int LANES   = N_GRP * 4;
    localparam int LATENCY = 2 + wv_pkg::tree_depth(N_GRP);
    localparam logic [LANES*COEF_W-1:0] COEFS_PAD = (LANES*COEF_W)'(COEFS);

    function automatic logic signed [SUM_W-1:0] total_abs();
        logic signed [SUM_W-1:0] acc;
        logic [COEF_W-1:0]       c;
        acc = '0;
        for (int i = 0; i < N_VOTES; i++) begin
            c = COEFS[i*COEF_W +: COEF_W];
            if (c[COEF_W-1]) acc = acc - {{(SUM_W-COEF_W){1'b1}}, c};
            else             acc = acc + {{(SUM_W-COEF_W){1'b0}}, c};
        end
        return acc;
    endfunction

    localparam logic signed [SUM_W-1:0] SCORE_ABS = total_abs();

    logic [LANES-1:0]        votes_pad;
    logic [N_GRP-1:0]        grp_vld;
    logic [N_GRP*SUM_W-1:0]  grp_sums;
    logic                    tree_vld;
    logic signed [SUM_W-1:0] tree_sum;

    assign votes_pad = LANES'(in_votes);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic signed [SUM_W-1:0] psum_g;
        wv_group_lut #(
            .COEF_W (COEF_W),
            .SUM_W  (SUM_W),
            .GCOEFS (COEFS_PAD[g*4*COEF_W +: 4*COEF_W])
        ) u_lut (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .votes     (votes_pad[g*4 +: 4]),
            .out_valid (grp_vld[g]),
            .psum      (psum_g)
        );
        assign grp_sums[g*SUM_W +: SUM_W] = psum_g;
    end

    wv_adder_tree #(
        .N_IN  (N_GRP),
        .SUM_W (SUM_W)
    ) u_tree (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (grp_vld[0]),
        .in_vals   (grp_sums),
        .out_valid (tree_vld),
        .out_sum   (tree_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_class <= 1'b0;
            out_score <= '0;
        end else begin
            out_valid <= tree_vld;
            if (tree_vld) begin
                out_score <= tree_sum;
                out_class <= ~tree_sum[SUM_W-1];
            end
        end
    end

    // R3: class agrees with the sign of the reported score, zero counted positive
    p_class_sign_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_class == ($signed(out_score) >= 0)));

    // R5: the score stays within the sum of coefficient magnitudes
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_score) <= SCORE_ABS && $signed(out_score) >= -SCORE_ABS));

    // R4: each result traces back to an accepted vector LATENCY cycles earlier
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LATENCY));

    // R6: outputs hold while no result is presented
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_score) && $stable(out_class)));
endmodule

// File: tb/tb_wv_boost_vote.sv
module tb_wv_boost_vote;
    localparam int CLK_PERIOD = 10;
    localparam int NV   = 10;
    localparam int CW   = 8;
    localparam int SW   = 12;
    localparam int LAT  = 4;
    localparam int NTAB = 9;
    localparam int QN   = 256;

    localparam int COEF [NV] = '{10, 20, 30, 40, 5, 15, 25, 35, 12, 8};

    // stimulus vectors and their hand-computed scores
    localparam logic [NV-1:0] TAB_V [NTAB] =
        '{10'h3FF, 10'h000, 10'h00F, 10'h0F0, 10'h300, 10'h008, 10'h2AA, 10'h155, 10'h1FF};
    localparam int TAB_S [NTAB] = '{200, -200, 0, -40, -160, -120, 36, -36, 184};

    logic          clk = 0;
    logic          rst = 1;
    logic          in_valid = 0;
    logic [NV-1:0] in_votes = '0;
    logic          out_valid;
    logic          out_class;
    logic [SW-1:0] out_score;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int q_score [QN];
    int q_due [QN];
    int q_wr = 0;
    int q_rd = 0;
    bit mon_on = 0;

    wv_boost_vote #(
        .N_VOTES (NV),
        .COEF_W  (CW),
        .COEFS   ({8'd8, 8'd12, 8'd35, 8'd25, 8'd15, 8'd5, 8'd40, 8'd30, 8'd20, 8'd10})
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_votes  (in_votes),
        .out_valid (out_valid),
        .out_class (out_class),
        .out_score (out_score)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model(input logic [NV-1:0] v);
        int s = 0;
        for (int i = 0; i < NV; i++) s += v[i] ? COEF[i] : -COEF[i];
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // drive one vector shortly after a rising edge
    task automatic send(input logic [NV-1:0] v);
        @(posedge clk); #2;
        in_valid = 1;
        in_votes = v;
        q_score[q_wr % QN] = model(v);
        q_due[q_wr % QN]   = cyc + LAT;
        q_wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 0;
            in_votes = NV'($urandom());
        end
    endtask

    // monitor: R2 score, R3 class, R4 timing and order
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (out_valid) begin
                if (q_rd == q_wr) begin
                    check("R4 unexpected valid", 1, 0);
                end else begin
                    check("R2 score", int'($signed(out_score)), q_score[q_rd % QN]);
                    check("R3 class", int'(out_class), (q_score[q_rd % QN] >= 0) ? 1 : 0);
                    check("R4 cycle", cyc, q_due[q_rd % QN]);
                    q_rd++;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int hold_s;
        int hold_c;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 class", int'(out_class), 0);
        check("R1 score", int'(out_score), 0);
        @(posedge clk); #2;
        rst = 0;
        @(negedge clk);
        check("R1 valid after release", int'(out_valid), 0);
        check("R1 score after release", int'(out_score), 0);
        mon_on = 1;

        // R2/R3/R5: table, checked against hand values, streamed back to back (R4)
        for (int i = 0; i < NTAB; i++) check("R2 table model", model(TAB_V[i]), TAB_S[i]);
        for (int i = 0; i < NTAB; i++) send(TAB_V[i]);
        idle(LAT + 2);
        check("R4 all table results seen", q_rd, q_wr);

        // R5 extremes with partly filled last group, isolated
        send(10'h3FF); idle(LAT + 1);
        check("R5 max positive", int'($signed(out_score)), 200);
        send(10'h000); idle(LAT + 1);
        check("R5 max negative", int'($signed(out_score)), -200);

        // R3 zero score gives class 1
        send(10'h00F); idle(LAT + 1);
        check("R3 zero score", int'($signed(out_score)), 0);
        check("R3 zero class", int'(out_class), 1);

        // R6: votes ignored while in_valid low, outputs hold
        hold_s = int'($signed(out_score));
        hold_c = int'(out_class);
        for (int i = 0; i < 6; i++) begin
            idle(1);
            @(negedge clk);
            check("R6 no valid when idle", int'(out_valid), 0);
            check("R6 score held", int'($signed(out_score)), hold_s);
            check("R6 class held", int'(out_class), hold_c);
        end

        // random streams with gaps, compared with the signed-sum model
        for (int i = 0; i < 60; i++) begin
            send(NV'($urandom()));
            if ((i % 7) == 3) idle(2);
        end
        idle(LAT + 2);
        check("R4 all random results seen", q_rd, q_wr);

        finish_run();
    end
endmodule